// File: doc/BRIEF.md
# Direct Digital Synthesis Waveform Generator

This block is a numerically controlled oscillator that turns a 32-bit tuning word into a stream of 8-bit samples of one of four periodic shapes: sine, square, sawtooth or triangle. A tuning register captures the word only when a load strobe is high. A phase accumulator adds the registered word on every clock. The top nine phase bits address a phase-to-amplitude stage. A sine table is built inside the block when it is elaborated, and the other three shapes are computed arithmetically from the address.

The selected sample is registered. It then passes through an amplitude stage that either multiplies or divides it by a small integer scale factor, and the result is registered again. The output frequency is the tuning word times the clock frequency divided by 2^32. A word of zero stops the phase.

Top module: `dds_wavegen`

## Requirements
- R1: The tuning register takes `tune_word` on a rising clock edge only while `tune_load` is 1. Otherwise it holds its value, and changes on `tune_word` without a load have no effect on the output.
- R2: While `rst_n` is 0, the tuning register, the phase, the registered sample and `wave_out` clear to 0 without waiting for a clock edge.
- R3: On every clock edge the phase becomes (phase + tuning register) mod 2^32. The table address is phase bits 31..23.
- R4: `wave_sel` picks the shape: 0 sine, 1 square, 2 sawtooth, 3 triangle. The sample computed from the phase and `wave_sel` present at edge k is registered at edge k. The amplitude result of that sample appears on `wave_out` after edge k+1.
- R5: For sine, the sample at address a is trunc(64.5 + 64*sin(2*pi*a/512)), with values in 0..128.
- R6: For square, the sample is 255 for addresses 0..255 and 0 for addresses 256..511.
- R7: For sawtooth, the sample is address/2 (rounded down), ramping from 0 to 255 once per period.
- R8: For triangle, the sample is the address for addresses up to 256 and 512 minus the address above that. The apex value 256 is clamped to 255.
- R9: With `amp_mul` = 1, the output is sample * `amp_scale`, saturated to 255.
- R10: With `amp_mul` = 0, the output is sample / `amp_scale` rounded down. A scale of 0 gives 0.
- R11: A tuning register of 0 freezes the phase, so `wave_out` stays constant while the other inputs are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tune_word | input | 32 | Frequency tuning word |
| tune_load | input | 1 | Load strobe for the tuning register |
| wave_sel | input | 2 | Waveform select |
| amp_mul | input | 1 | 1 multiplies, 0 divides by the scale |
| amp_scale | input | 4 | Amplitude scale factor |
| wave_out | output | 8 | Output sample |

## Verification
A tuning word of 2^23 steps the address by exactly one per clock. Each shape is therefore swept over all 512 addresses under several scale settings: unity multiply and divide, which expose the raw shape; a large multiplier, which exposes saturation; and divide by 3 and by 0. Changing `wave_sel` on every cycle separates a correct two-stage latency from an off-by-one, because a stale select yields a different shape. Further runs use odd tuning words near 2^31 and 2^32 to exercise accumulator wrap, apply tuning words without the strobe to show they are ignored, load a zero word to freeze the output, and assert reset in the middle of a cycle to show that the clear does not wait for a clock edge.

// File: rtl/dds_wavegen.sv
module dds_wavegen #(
  parameter int PHASE_W  = 32,
  parameter int ADDR_W   = 9,
  parameter int SAMPLE_W = 8,
  parameter int SCALE_W  = 4,
  parameter int SINE_MID = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PHASE_W-1:0]  tune_word,
  input  logic                tune_load,
  input  logic [1:0]          wave_sel,
  input  logic                amp_mul,
  input  logic [SCALE_W-1:0]  amp_scale,
  output logic [SAMPLE_W-1:0] wave_out
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0]   HALF_A  = ADDR_W'(DEPTH / 2);
  localparam logic [ADDR_W:0]     DEPTH_V = (ADDR_W+1)'(DEPTH);
  localparam logic [ADDR_W:0]     SMAX_V  = (ADDR_W+1)'((1 << SAMPLE_W) - 1);
  localparam logic [SAMPLE_W-1:0] SMAX    = '1;

  function automatic logic [SAMPLE_W-1:0] sine_val(int idx);
    real r;
    r = real'(SINE_MID) + 0.5 +
        real'(SINE_MID) * $sin(2.0 * 3.14159265358979 * real'(idx) / real'(DEPTH));
    return SAMPLE_W'($rtoi(r));
  endfunction

  logic [PHASE_W-1:0]  tune_q, phase_q;
  logic [SAMPLE_W-1:0] sample_q, sample_d, amp_d;
  logic [SAMPLE_W-1:0] sine_rom [DEPTH];

  wire [ADDR_W-1:0] addr = phase_q[PHASE_W-1 -: ADDR_W];

  for (genvar g = 0; g < DEPTH; g++) begin : g_sine
    assign sine_rom[g] = sine_val(g);
  end

  wire [ADDR_W:0] tri_full = (addr <= HALF_A) ? {1'b0, addr} : DEPTH_V - {1'b0, addr};
  wire [SAMPLE_W-1:0] tri_s  = (tri_full > SMAX_V) ? SMAX : tri_full[SAMPLE_W-1:0];
  wire [ADDR_W-1:0]   saw_w  = addr >> 1;
  wire [SAMPLE_W-1:0] sq_s   = (addr < HALF_A) ? SMAX : '0;

  always_comb begin
    case (wave_sel)
      2'd0:    sample_d = sine_rom[addr];
      2'd1:    sample_d = sq_s;
      2'd2:    sample_d = saw_w[SAMPLE_W-1:0];
      default: sample_d = tri_s;
    endcase
  end

  wire [SAMPLE_W+SCALE_W-1:0] prod =
    {{SCALE_W{1'b0}}, sample_q} * {{SAMPLE_W{1'b0}}, amp_scale};
  wire [SAMPLE_W-1:0] quot = (amp_scale == '0) ? '0 :
    sample_q / {{(SAMPLE_W-SCALE_W){1'b0}}, amp_scale};

  assign amp_d = amp_mul ? ((|prod[SAMPLE_W+SCALE_W-1:SAMPLE_W]) ? SMAX : prod[SAMPLE_W-1:0])
                         : quot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tune_q   <= '0;
      phase_q  <= '0;
      sample_q <= '0;
      wave_out <= '0;
    end else begin
      if (tune_load) tune_q <= tune_word;
      phase_q  <= phase_q + tune_q;
      sample_q <= sample_d;
      wave_out <= amp_d;
    end
  end

  assert_tune_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tune_load |=> $stable(tune_q));
  assert_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tune_q == '0) |=> $stable(phase_q));
  assert_sine_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_sel == 2'd0) |=> (sample_q <= SAMPLE_W'(2 * SINE_MID)));
  assert_div_shrinks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !amp_mul |=> (wave_out <= $past(sample_q)));
  assert_div_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!amp_mul && amp_scale == '0) |=> (wave_out == '0));
  assert_mul_grows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_mul && amp_scale != '0) |=> (wave_out >= $past(sample_q)));
endmodule

// File: tb/tb_dds_wavegen.sv
module tb_dds_wavegen;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] tune_word = 0;
  logic        tune_load = 0;
  logic [1:0]  wave_sel = 0;
  logic        amp_mul = 1;
  logic [3:0]  amp_scale = 1;
  logic [7:0]  wave_out;

  int checks = 0, errors = 0;
  bit check_en = 0;
  string cur_tag = "R4";

  dds_wavegen dut (.clk(clk), .rst_n(rst_n), .tune_word(tune_word), .tune_load(tune_load),
                   .wave_sel(wave_sel), .amp_mul(amp_mul), .amp_scale(amp_scale),
                   .wave_out(wave_out));

  always #10 clk = ~clk;

  function automatic int exp_sample(int a, int sel);
    int t;
    case (sel)
      0: return $rtoi(64.5 + 64.0 * $sin(2.0 * 3.14159265358979 * a / 512.0));
      1: return (a < 256) ? 255 : 0;
      2: return a / 2;
      default: begin
        t = (a <= 256) ? a : 512 - a;
        return (t > 255) ? 255 : t;
      end
    endcase
  endfunction

  function automatic int exp_amp(int s, bit mul, int sc);
    if (mul) return (s * sc > 255) ? 255 : s * sc;
    return (sc == 0) ? 0 : s / sc;
  endfunction

  logic [31:0] m_tune, m_phase;
  int m_sample, m_out;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tune <= 0; m_phase <= 0; m_sample <= 0; m_out <= 0;
    end else begin
      if (tune_load) m_tune <= tune_word;
      m_phase  <= m_phase + m_tune;
      m_sample <= exp_sample(int'(m_phase[31:23]), int'(wave_sel));
      m_out    <= exp_amp(m_sample, amp_mul, int'(amp_scale));
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: wave_out=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (check_en) check(cur_tag, int'(wave_out), m_out);

  function automatic string cfg_tag(int sel, bit mul, int sc);
    if (mul && sc != 1) return "R9";
    if (!mul && sc != 1) return "R10";
    case (sel)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic load(logic [31:0] w);
    tune_word = w; tune_load = 1;
    step(1);
    tune_load = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int held;
    step(3);
    check("R2", int'(wave_out), 0);
    rst_n = 1;
    check_en = 1;

    cur_tag = "R4";
    load(32'h0080_0000);
    for (int i = 0; i < 64; i++) begin
      wave_sel = 2'(i % 4);
      step(1);
    end

    for (int sel = 0; sel < 4; sel++) begin
      for (int c = 0; c < 6; c++) begin
        wave_sel = 2'(sel);
        case (c)
          0: begin amp_mul = 1; amp_scale = 1; end
          1: begin amp_mul = 0; amp_scale = 1; end
          2: begin amp_mul = 1; amp_scale = 2; end
          3: begin amp_mul = 1; amp_scale = 15; end
          4: begin amp_mul = 0; amp_scale = 3; end
          default: begin amp_mul = 0; amp_scale = 0; end
        endcase
        step(2);
        cur_tag = cfg_tag(sel, amp_mul, int'(amp_scale));
        step(520);
      end
    end

    amp_mul = 1; amp_scale = 1; wave_sel = 2'd2;
    step(2);
    cur_tag = "R1";
    for (int i = 0; i < 300; i++) begin
      tune_word = 32'h1234_5678 * (i + 1);
      step(1);
    end

    cur_tag = "R3";
    wave_sel = 2'd3;
    load(32'h7FFF_FFFF);
    step(200);
    load(32'hFF80_0001);
    step(200);
    load(32'hC000_0003);
    step(200);

    cur_tag = "R11";
    wave_sel = 2'd0;
    load(32'h0);
    step(3);
    held = int'(wave_out);
    for (int i = 0; i < 50; i++) begin
      step(1);
      check("R11", int'(wave_out), held);
    end

    cur_tag = "R2";
    load(32'h0080_0000);
    amp_mul = 1; amp_scale = 1; wave_sel = 2'd1;
    step(10);
    rst_n = 0;
    #1;
    check("R2", int'(wave_out), 0);
    step(2);
    check("R2", int'(wave_out), 0);
    rst_n = 1;
    step(20);

    check_en = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule